// File: doc/BRIEF.md
# Parallel Signature Compactor

This block folds a word of parallel response bits into a short signature on every enabled clock. Its core is a modular (internal-XOR) linear feedback shift register. Each response bit is XORed into its own stage, so every output of the circuit under test feeds the same register at once.

The register is linear. The signature after a run is therefore the XOR of the signatures that each response stream would leave if it were fed in alone. A faulty response gives the expected signature with a probability of roughly 2^-n for an n-bit register.

A synchronous clear seeds the register with zeros before a run, and an enable freezes it between runs. A golden signature can be loaded into a holding register. An equality flag then reports, at every cycle, whether the current signature equals that golden value.

Top module: `misr_sig`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `sig_o` is 000, the stored golden value is 000, and `match_o` is 1.
- R2: When `clr` is high at a rising edge, the next `sig_o` is all zeros, whatever the values of `en` and `data_i`.
- R3: When `clr` and `en` are both low at a rising edge, `sig_o` keeps its value, whatever the value of `data_i`.
- R4: When `en` is high and `clr` is low, the next bit 0 of `sig_o` equals the current bit 2 XOR `data_i[0]`.
- R5: When `en` is high and `clr` is low, the next bit 1 of `sig_o` equals the current bit 0 XOR the current bit 2 XOR `data_i[1]`.
- R6: When `en` is high and `clr` is low, the next bit 2 of `sig_o` equals the current bit 1 XOR `data_i[2]`.
- R7: With `data_i` held at zero and a nonzero start state, the register visits 7 distinct states and returns to the start state after exactly 7 enabled cycles.
- R8: When two streams start from the cleared state, the signature of their bitwise XOR equals the XOR of their two separate signatures. In particular, an all-zero input keeps an all-zero state at zero.
- R9: A high `gold_ld` at a rising edge stores `gold_i`. `match_o` is 1 exactly when `sig_o` equals the stored value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of the signature to zero |
| en | input | 1 | Compaction enable |
| data_i | input | W (3) | Parallel response bits, one per stage |
| gold_ld | input | 1 | Load strobe for the golden signature |
| gold_i | input | W (3) | Golden signature value |
| sig_o | output | W (3) | Current signature |
| match_o | output | 1 | High when the signature equals the stored golden value |

## Verification
The bench builds the block with its default width of 3 and feedback tap vector 010. These values give the three-stage update equations that the bench models on its own. The state space of only seven nonzero states lets the bench walk the complete autonomous cycle and confirm its length. It also injects each input bit in isolation and compares a combined stream against the XOR of its parts, which tests superposition directly.

// File: rtl/misr_pkg.sv
package misr_pkg;

    // Default signature width and modular feedback taps (bit i set:
    // top stage is XORed into stage i in addition to its shift input).
    parameter int SIG_W = 3;
    parameter logic [SIG_W-1:0] SIG_TAPS = 3'b010;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_SHIFT = 2'd1,
        OP_CLEAR = 2'd2
    } op_e;

    typedef struct packed {
        logic clr;
        logic en;
    } ctrl_t;

    function automatic op_e decode_op(input ctrl_t c);
        if (c.clr)     return OP_CLEAR;
        else if (c.en) return OP_SHIFT;
        else           return OP_HOLD;
    endfunction

endpackage

// File: rtl/misr_cell.sv
module misr_cell #(
    parameter bit TAP = 1'b0
) (
    input  logic           clk,
    input  logic           rst,
    input  misr_pkg::op_e  op,
    input  logic           shift_in,
    input  logic           fb,
    input  logic           d,
    output logic           q
);
    import misr_pkg::*;

    logic nxt;

    always_comb begin
        unique case (op)
            OP_CLEAR: nxt = 1'b0;
            OP_SHIFT: nxt = shift_in ^ (TAP & fb) ^ d;
            default:  nxt = q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= nxt;
    end

    AST_CELL_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (op == OP_CLEAR) |=> (q == 1'b0)); // R2

endmodule

// File: rtl/misr_golden.sv
module misr_golden #(
    parameter int W = misr_pkg::SIG_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] gold_i,
    input  logic [W-1:0] sig,
    output logic         match
);
    logic [W-1:0] golden_q;

    always_ff @(posedge clk) begin
        if (rst)     golden_q <= '0;
        else if (ld) golden_q <= gold_i;
    end

    assign match = (sig == golden_q);

    AST_GOLD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        ld |=> (golden_q == $past(gold_i))); // R9
    AST_GOLD_KEPT: assert property (@(posedge clk) disable iff (rst)
        !ld |=> $stable(golden_q)); // R9

endmodule

// File: rtl/misr_sig.sv
module misr_sig #(
    parameter int W = misr_pkg::SIG_W,
    parameter logic [W-1:0] TAPS = misr_pkg::SIG_TAPS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] data_i,
    input  logic         gold_ld,
    input  logic [W-1:0] gold_i,
    output logic [W-1:0] sig_o,
    output logic         match_o
);
    import misr_pkg::*;

    localparam int TOP = W - 1;

    ctrl_t        ctrl;
    op_e          op;
    logic [W-1:0] state;
    logic         fb;

    assign ctrl = '{clr: clr, en: en};
    assign op   = decode_op(ctrl);
    assign fb   = state[TOP];

    generate
        for (genvar i = 0; i < W; i++) begin : g_stage
            if (i == 0) begin : g_head
                misr_cell #(.TAP(1'b0)) cell_i (
                    .clk(clk), .rst(rst), .op(op),
                    .shift_in(fb), .fb(fb), .d(data_i[i]), .q(state[i])
                );
            end else begin : g_body
                misr_cell #(.TAP(TAPS[i])) cell_i (
                    .clk(clk), .rst(rst), .op(op),
                    .shift_in(state[i-1]), .fb(fb), .d(data_i[i]), .q(state[i])
                );
            end
        end
    endgenerate

    misr_golden #(.W(W)) gold_u (
        .clk(clk), .rst(rst), .ld(gold_ld), .gold_i(gold_i),
        .sig(state), .match(match_o)
    );

    assign sig_o = state;

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        clr |=> (sig_o == '0)); // R2
    AST_HOLD_STILL: assert property (@(posedge clk) disable iff (rst)
        (!clr && !en) |=> $stable(sig_o)); // R3
    AST_ZERO_STAYS: assert property (@(posedge clk) disable iff (rst)
        (en && !clr && sig_o == '0 && data_i == '0) |=> (sig_o == '0)); // R8
    AST_RESET_ZERO: assert property (@(posedge clk)
        rst |=> (sig_o == '0)); // R1

endmodule

// File: tb/misr_sig_tb_top.sv
`timescale 1ns/1ps
module misr_sig_tb_top;

    typedef struct {
        logic [2:0] s;
        logic       m;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clr = 1'b0;
    logic       en = 1'b0;
    logic [2:0] data_i = '0;
    logic       gold_ld = 1'b0;
    logic [2:0] gold_i = '0;
    logic [2:0] sig_o;
    logic       match_o;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    item_t sb[$];
    logic [2:0] mstate = '0;
    logic [2:0] mgold = '0;

    always #5 clk = ~clk;

    misr_sig dut_i (
        .clk(clk), .rst(rst), .clr(clr), .en(en), .data_i(data_i),
        .gold_ld(gold_ld), .gold_i(gold_i), .sig_o(sig_o), .match_o(match_o)
    );

    function automatic logic [2:0] ref_next(input logic [2:0] s, input logic [2:0] d);
        logic [2:0] n;
        n[0] = s[2] ^ d[0];
        n[1] = s[0] ^ s[2] ^ d[1];
        n[2] = s[1] ^ d[2];
        return n;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Driver: applies one cycle of stimulus and pushes the expected result.
    task automatic step(input logic c, input logic e, input logic [2:0] d,
                        input logic l, input logic [2:0] g, input string tag);
        item_t it;
        @(negedge clk);
        clr = c; en = e; data_i = d; gold_ld = l; gold_i = g;
        if (c)      mstate = '0;
        else if (e) mstate = ref_next(mstate, d);
        if (l)      mgold = g;
        it.s = mstate; it.m = (mstate == mgold); it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic hold();
        step(1'b0, 1'b0, 3'b000, 1'b0, 3'b000, "R3 hold");
    endtask

    // Monitor: compares after every rising edge.
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check(sig_o === it.s, {it.tag, " sig"}, int'(sig_o), int'(it.s));
            check(match_o === it.m, {it.tag, " match"}, int'(match_o), int'(it.m));
        end
    end

    task automatic run_stream(input logic [2:0] st [8], output logic [2:0] res);
        step(1'b1, 1'b0, 3'b000, 1'b0, 3'b000, "R2 clear");
        for (int k = 0; k < 8; k++) step(1'b0, 1'b1, st[k], 1'b0, 3'b000, "R8 stream");
        hold();
        @(negedge clk);
        res = sig_o;
    endtask

    initial begin
        logic [2:0] sa, sb_sig, sc;
        logic [2:0] a [8];
        logic [2:0] b [8];
        logic [2:0] c [8];
        int period;
        repeat (3) @(negedge clk);
        check(sig_o === 3'b000, "R1 reset sig", int'(sig_o), 0);
        check(match_o === 1'b1, "R1 reset match", int'(match_o), 1);
        rst = 1'b0;
        @(negedge clk);
        check(sig_o === 3'b000, "R1 after reset", int'(sig_o), 0);

        // Single-bit injections from zero
        step(1'b0, 1'b1, 3'b001, 1'b0, 3'b000, "R4 inject d0");
        step(1'b1, 1'b0, 3'b000, 1'b0, 3'b000, "R2 clear");
        step(1'b0, 1'b1, 3'b010, 1'b0, 3'b000, "R5 inject d1");
        step(1'b1, 1'b0, 3'b000, 1'b0, 3'b000, "R2 clear");
        step(1'b0, 1'b1, 3'b100, 1'b0, 3'b000, "R6 inject d2");
        // state 100: feedback into stages 0 and 1
        step(1'b0, 1'b1, 3'b000, 1'b0, 3'b000, "R4 R5 feedback");
        step(1'b0, 1'b1, 3'b111, 1'b0, 3'b000, "R6 all data");
        step(1'b0, 1'b1, 3'b101, 1'b0, 3'b000, "R5 mixed");
        // Hold with busy data
        step(1'b0, 1'b0, 3'b111, 1'b0, 3'b000, "R3 hold busy");
        step(1'b0, 1'b0, 3'b010, 1'b0, 3'b000, "R3 hold busy");
        // Clear beats enable
        step(1'b1, 1'b1, 3'b111, 1'b0, 3'b000, "R2 clear over en");

        // Autonomous period from 001
        step(1'b0, 1'b1, 3'b001, 1'b0, 3'b000, "R7 seed");
        period = 0;
        for (int k = 1; k <= 7; k++) begin
            step(1'b0, 1'b1, 3'b000, 1'b0, 3'b000, "R7 run");
            hold();
            @(negedge clk);
            if (sig_o == 3'b001 && period == 0) period = k;
            check(sig_o !== 3'b000, "R7 nonzero", int'(sig_o), 1);
        end
        check(period == 7, "R7 period", period, 7);

        // Superposition
        a = '{3'b101, 3'b010, 3'b111, 3'b000, 3'b011, 3'b100, 3'b001, 3'b110};
        b = '{3'b011, 3'b110, 3'b001, 3'b101, 3'b000, 3'b111, 3'b010, 3'b100};
        for (int k = 0; k < 8; k++) c[k] = a[k] ^ b[k];
        run_stream(a, sa);
        run_stream(b, sb_sig);
        run_stream(c, sc);
        check(sc === (sa ^ sb_sig), "R8 superposition", int'(sc), int'(sa ^ sb_sig));
        run_stream('{default: 3'b000}, sc);
        check(sc === 3'b000, "R8 zero stream", int'(sc), 0);

        // Golden compare
        step(1'b1, 1'b0, 3'b000, 1'b1, 3'b110, "R9 load golden");
        step(1'b0, 1'b1, 3'b110, 1'b0, 3'b000, "R9 reach golden");
        step(1'b0, 1'b1, 3'b000, 1'b0, 3'b011, "R9 leave golden");
        step(1'b0, 1'b0, 3'b000, 1'b1, 3'b101, "R9 reload");
        hold();
        @(negedge clk);
        check(match_o === (sig_o == 3'b101), "R9 match final",
              int'(match_o), int'(sig_o == 3'b101));
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule